// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recent virtual-to-physical page translations so that a processor request can usually be translated without a page-table walk. A request carries a virtual address and a read/write flag. The block splits the address into a page number and an in-page offset, and compares the page number against every stored entry at once. On a match it returns the physical address, which is the stored physical page number joined to the untouched offset. It also checks the access against the entry's write permission.

When no entry matches, the block asks an external page-table walker for the translation over a simple request/response port. It stores the answer and then serves the original request from the new entry. Free slots are filled first. When every slot is occupied, the least recently used entry is replaced. A write to a clean, writable entry marks it modified and reports that it did so, so that the caller can update its page table. A flush input, used on a process switch, drops every translation.

Top module: `tlb_fa`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `walk_req_valid` are 0, and no entry is valid, so the first access of any page needs a walk.
- R2: A request accepted on a rising edge whose page number matches a valid entry raises `resp_valid` for one cycle on the second rising edge after acceptance, with no walk request.
- R3: `resp_paddr` equals the entry's physical page number in bits [PA_W-1:12] and the request's address bits [11:0] in bits [11:0].
- R4: On a miss `walk_req_valid` rises with `walk_vpn` equal to request address bits [VA_W-1:12]. Both are held until `walk_resp_valid`. The returned translation is then stored and the request is answered as a hit, on the second rising edge after the walk response.
- R5: While any entry is invalid, a refill goes to an invalid entry, so no stored translation is lost.
- R6: When all entries are valid, a refill replaces the entry whose last successful use (hit or refill) is the oldest.
- R7: A write hitting a writable entry whose modified bit is clear gives `resp_set_dirty`=1 and sets the bit. Later writes to that entry, and all reads, give 0.
- R8: A write hitting an entry with `walk_resp_writable`=0 stored gives `resp_fault`=1, `resp_paddr`=0 and `resp_set_dirty`=0, and does not change the entry's recency or modified bit.
- R9: A cycle with `flush`=1 invalidates every entry by the next cycle, so every later access of a previously stored page needs a walk.
- R10: `resp_valid` is never high on two consecutive cycles, and `req_ready` is 0 from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | VA_W | Virtual address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | PA_W | Translated physical address (0 on fault) |
| resp_fault | output | 1 | Write to a read-only page |
| resp_set_dirty | output | 1 | This write set the entry's modified bit |
| walk_req_valid | output | 1 | Walk request to the page-table walker |
| walk_vpn | output | VA_W-12 | Page number to be walked |
| walk_resp_valid | input | 1 | Walker answer present |
| walk_resp_ppn | input | PA_W-12 | Physical page number from the walker |
| walk_resp_writable | input | 1 | Page may be written |

## Verification
The assertions assume that the environment offers a request only while `req_ready` is high, and answers a walk only while `walk_req_valid` is high, with exactly one single-cycle `walk_resp_valid`. They also assume that the walker's answers for a page do not change between walks. The bench drives every input on the falling edge and raises `req_valid` only from the idle state. Its walker model answers each walk one cycle after it appears, using a fixed function of the page number: odd page numbers are read-only. `flush` is pulsed only while the block is idle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } tlb_state_e;

  // index of the lowest set bit (0 when none is set)
  function automatic logic [5:0] lowest_set(input logic [63:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [VPN_W-1:0]   vpn_arr [ENTRIES],
  input  logic [VPN_W-1:0]   key,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (vpn_arr[g] == key);
  end

  assign hit     = |hit_vec;
  assign hit_idx = IDX_W'(tlb_pkg::lowest_set(64'(hit_vec)));

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);

  // rel[i][j] = 1 : entry i used more recently than entry j
  logic [ENTRIES-1:0] rel [ENTRIES];
  logic [ENTRIES-1:0] lru_vec;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < ENTRIES; i++) rel[i] <= '0;
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx) rel[i] <= ~(ENTRIES'(1) << i);
        else                        rel[i][touch_idx] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign lru_vec[g] = ~|rel[g];
  end

  always_comb begin
    if (!(&valid_vec)) victim_idx = IDX_W'(tlb_pkg::lowest_set(64'(~valid_vec)));
    else               victim_idx = IDX_W'(tlb_pkg::lowest_set(64'(lru_vec)));
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_fault,
  output logic              resp_set_dirty,
  output logic              walk_req_valid,
  output logic [VA_W-OFF_W-1:0] walk_vpn,
  input  logic              walk_resp_valid,
  input  logic [PA_W-OFF_W-1:0] walk_resp_ppn,
  input  logic              walk_resp_writable
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [PA_W-1:0] make_paddr(input logic [PPN_W-1:0] p,
                                                  input logic [OFF_W-1:0] o);
    return {p, o};
  endfunction

  tlb_state_e         state;
  logic               q_write;
  logic [VPN_W-1:0]   q_vpn;
  logic [OFF_W-1:0]   q_off;

  logic [ENTRIES-1:0] e_valid;
  logic [ENTRIES-1:0] e_dirty;
  logic [ENTRIES-1:0] e_wr;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;

  // named internal events
  logic acc_hit, acc_fault, acc_mark, do_install, lru_touch;
  logic [IDX_W-1:0] touch_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) cam_i (
    .valid_vec (e_valid),
    .vpn_arr   (e_vpn),
    .key       (q_vpn),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  assign acc_hit    = (state == ST_LOOK) && hit;
  assign acc_fault  = acc_hit && q_write && !e_wr[hit_idx];
  assign acc_mark   = acc_hit && q_write && e_wr[hit_idx] && !e_dirty[hit_idx];
  assign do_install = (state == ST_WAIT) && walk_resp_valid;
  assign lru_touch  = do_install || (acc_hit && !acc_fault);
  assign touch_idx  = do_install ? victim_idx : hit_idx;

  tlb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) lru_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (flush),
    .touch      (lru_touch),
    .touch_idx  (touch_idx),
    .valid_vec  (e_valid),
    .victim_idx (victim_idx)
  );

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q_write <= 1'b0;
      q_vpn   <= '0;
      q_off   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state   <= ST_LOOK;
          q_write <= req_write;
          q_vpn   <= req_vaddr[VA_W-1:OFF_W];
          q_off   <= req_vaddr[OFF_W-1:0];
        end
        ST_LOOK: state <= hit ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (walk_resp_valid) state <= ST_LOOK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // entry flags
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      e_valid <= '0;
      e_dirty <= '0;
      e_wr    <= '0;
    end else if (do_install) begin
      e_valid[victim_idx] <= 1'b1;
      e_dirty[victim_idx] <= 1'b0;
      e_wr[victim_idx]    <= walk_resp_writable;
    end else if (acc_mark) begin
      e_dirty[hit_idx] <= 1'b1;
    end
  end

  // entry payload
  always_ff @(posedge clk) begin
    if (do_install) begin
      e_vpn[victim_idx] <= q_vpn;
      e_ppn[victim_idx] <= walk_resp_ppn;
    end
  end

  // response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_paddr     <= '0;
      resp_fault     <= 1'b0;
      resp_set_dirty <= 1'b0;
    end else begin
      resp_valid     <= acc_hit;
      resp_paddr     <= acc_fault ? '0 : make_paddr(e_ppn[hit_idx], q_off);
      resp_fault     <= acc_fault;
      resp_set_dirty <= acc_mark;
    end
  end

  assign req_ready      = (state == ST_IDLE);
  assign walk_req_valid = (state == ST_WAIT);
  assign walk_vpn       = q_vpn;

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               req_valid,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic               resp_set_dirty,
  input logic               walk_req_valid,
  input logic               walk_resp_valid,
  input logic [VPN_W-1:0]   walk_vpn,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               do_install,
  input logic [IDX_W-1:0]   victim_idx
);

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !req_ready); // R10

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_resp_valid) |=> (walk_req_valid && $stable(walk_vpn))); // R4

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!resp_valid && !walk_req_valid)); // R2

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R9

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (do_install && !(&valid_vec)) |-> !valid_vec[victim_idx]); // R5

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> !resp_set_dirty); // R8

endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush           (flush),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .resp_valid      (resp_valid),
  .resp_fault      (resp_fault),
  .resp_set_dirty  (resp_set_dirty),
  .walk_req_valid  (walk_req_valid),
  .walk_resp_valid (walk_resp_valid),
  .walk_vpn        (walk_vpn),
  .hit_vec         (hit_vec),
  .valid_vec       (e_valid),
  .do_install      (do_install),
  .victim_idx      (victim_idx)
);

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_fault;
  logic        resp_set_dirty;
  logic        walk_req_valid;
  logic [19:0] walk_vpn;
  logic        walk_resp_valid = 1'b0;
  logic [19:0] walk_resp_ppn = '0;
  logic        walk_resp_writable = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tlb_fa dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .resp_set_dirty(resp_set_dirty),
    .walk_req_valid(walk_req_valid), .walk_vpn(walk_vpn),
    .walk_resp_valid(walk_resp_valid), .walk_resp_ppn(walk_resp_ppn),
    .walk_resp_writable(walk_resp_writable)
  );

  // walker model
  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    return 20'((v * 7) + 20'h3A5);
  endfunction
  function automatic logic wr_of(input logic [19:0] v);
    return ~v[0];
  endfunction

  // reference translation store
  bit          ref_valid [N];
  logic [19:0] ref_vpn   [N];
  bit          ref_wr    [N];
  bit          ref_dirty [N];
  int unsigned ref_stamp [N];
  int unsigned tick = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ref_flush();
    for (int i = 0; i < N; i++) ref_valid[i] = 1'b0;
  endtask

  task automatic ref_access(input bit wr, input logic [31:0] va,
                            output bit miss, output bit fault,
                            output logic [31:0] pa, output bit sd);
    int idx;
    logic [19:0] v;
    v = va[31:12];
    idx = -1;
    for (int i = 0; i < N; i++) if (ref_valid[i] && ref_vpn[i] == v) idx = i;
    miss = (idx < 0);
    if (miss) begin
      for (int i = N - 1; i >= 0; i--) if (!ref_valid[i]) idx = i;
      if (idx < 0) begin
        idx = 0;
        for (int i = 1; i < N; i++) if (ref_stamp[i] < ref_stamp[idx]) idx = i;
      end
      ref_valid[idx] = 1'b1;
      ref_vpn[idx]   = v;
      ref_wr[idx]    = wr_of(v);
      ref_dirty[idx] = 1'b0;
      tick++;
      ref_stamp[idx] = tick;
    end
    fault = wr && !ref_wr[idx];
    sd = 1'b0;
    if (!fault) begin
      tick++;
      ref_stamp[idx] = tick;
      sd = wr && !ref_dirty[idx];
      if (sd) ref_dirty[idx] = 1'b1;
    end
    pa = fault ? 32'h0 : {ppn_of(v), va[11:0]};
  endtask

  // drive one access, serve walks, compare with the reference
  task automatic access(input string req, input bit wr, input logic [31:0] va);
    bit miss_seen, e_miss, e_fault, e_sd;
    logic [31:0] e_pa;
    int cnt;
    miss_seen = 1'b0;
    cnt = 0;
    ref_access(wr, va, e_miss, e_fault, e_pa, e_sd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10", "ready while busy", 64'(req_ready), 64'd0);
    while (!resp_valid && cnt < 20) begin
      if (walk_req_valid) begin
        miss_seen = 1'b1;
        check(walk_vpn == va[31:12], "R4", "walk page number", 64'(walk_vpn), 64'(va[31:12]));
        walk_resp_valid = 1'b1;
        walk_resp_ppn = ppn_of(walk_vpn);
        walk_resp_writable = wr_of(walk_vpn);
      end else begin
        walk_resp_valid = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    walk_resp_valid = 1'b0;
    check(resp_valid, req, "response arrived", 64'(resp_valid), 64'd1);
    check(miss_seen == e_miss, e_miss ? "R4" : "R2", "walk needed", 64'(miss_seen), 64'(e_miss));
    check(cnt == (e_miss ? 3 : 1), e_miss ? "R4" : "R2", "response latency", 64'(cnt),
          64'(e_miss ? 3 : 1));
    check(resp_paddr == e_pa, e_fault ? "R8" : "R3", "physical address", 64'(resp_paddr), 64'(e_pa));
    check(resp_fault == e_fault, "R8", "fault flag", 64'(resp_fault), 64'(e_fault));
    check(resp_set_dirty == e_sd, "R7", "set-dirty flag", 64'(resp_set_dirty), 64'(e_sd));
    @(negedge clk);
    check(!resp_valid, "R10", "response pulse width", 64'(resp_valid), 64'd0);
  endtask

  function automatic logic [31:0] va_of(input logic [19:0] v, input logic [11:0] o);
    return {v, o};
  endfunction

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", 64'(resp_valid), 64'd0);
    check(walk_req_valid == 1'b0, "R1", "walk after reset", 64'(walk_req_valid), 64'd0);
    access("R1", 1'b0, va_of(20'h00400, 12'h123));
  endtask

  task automatic t_fill();
    for (int k = 0; k < N; k++) access("R5", 1'b0, va_of(20'h01000 + 20'(k), 12'(k * 5)));
    for (int k = 0; k < N; k++) access("R5", 1'b0, va_of(20'h01000 + 20'(k), 12'hFFF));
  endtask

  task automatic t_lru_fault();
    // base+0 used again: base+1 (read-only) becomes oldest
    access("R6", 1'b0, va_of(20'h01000, 12'h010));
    access("R8", 1'b1, va_of(20'h01001, 12'h020));
    access("R6", 1'b0, va_of(20'h02000, 12'h000)); // evicts base+1
    access("R6", 1'b0, va_of(20'h01001, 12'h030)); // walks again, evicts base+2
    access("R6", 1'b0, va_of(20'h01003, 12'h040)); // still present
    access("R6", 1'b0, va_of(20'h01002, 12'h050)); // evicted earlier
  endtask

  task automatic t_dirty();
    access("R7", 1'b1, va_of(20'h01004, 12'h100));
    access("R7", 1'b1, va_of(20'h01004, 12'h104));
    access("R7", 1'b0, va_of(20'h01004, 12'h108));
    access("R7", 1'b1, va_of(20'h03000, 12'h00C)); // write miss on writable page
  endtask

  task automatic t_offsets();
    access("R3", 1'b0, va_of(20'h01006, 12'h000));
    access("R3", 1'b0, va_of(20'h01006, 12'hFFF));
    access("R3", 1'b0, va_of(20'hFFFFF, 12'hA5A));
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    ref_flush();
    check(req_ready == 1'b1, "R9", "ready after flush", 64'(req_ready), 64'd1);
    access("R9", 1'b0, va_of(20'h01006, 12'h001));
    access("R9", 1'b0, va_of(20'h01007, 12'h002));
    access("R9", 1'b0, va_of(20'h01006, 12'h003));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      ref_valid[i] = 1'b0; ref_vpn[i] = '0; ref_wr[i] = 1'b0;
      ref_dirty[i] = 1'b0; ref_stamp[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_lru_fault();
    t_dirty();
    t_offsets();
    t_flush();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule